// File: doc/BRIEF.md
# Effective Address Generator

This block turns one memory-operand request into the 24-bit address that goes to the memory system. Each request carries an addressing mode, an operand size, the value of the selected base address register, the value of an optional index register, the program counter as it stands on the extension word, and up to two extension words that an upstream fetch stage has already collected. The block adds the right operands on a 32-bit datapath and drives out the low 24 bits. For the auto-modify modes it also returns the new base register value and a write-back strobe.

There are nine supported modes: plain register indirect, post-increment, pre-decrement, register plus 16-bit displacement, register plus index plus 8-bit displacement, the two PC-relative counterparts of those two, and absolute short and long addresses. The result is registered, so every accepted request gives one result exactly one clock later. A new request may be presented on every cycle. A word or long access to an odd address is flagged rather than corrected.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid`, `wb_en` and `out_align_err` are 0.
- R2: A request with `req_valid`=1 and a mode code from 0 to 8 produces `out_valid`=1 on the next clock edge. A request with a mode code from 9 to 15, or a cycle without `req_valid`, produces `out_valid`=0 on that edge.
- R3: Mode 0 (indirect): the address is the base register value and `wb_en` stays 0.
- R4: Mode 1 (post-increment): the address is the base value unchanged, and `wb_value` is the base plus the step. The step is 1 for size code 0 (byte), 2 for size code 1 (word), and 4 for size codes 2 and 3 (long).
- R5: Mode 2 (pre-decrement): the base minus the step is both the address and `wb_value`.
- R6: Mode 3: the address is the base plus `ext_word0`, read as a signed 16-bit value.
- R7: Mode 4: the address is the base plus the full 32-bit index value plus `ext_word0[7:0]`, read as a signed 8-bit value.
- R8: Modes 5 and 6 form the same sums as modes 3 and 4, with `ext_pc` in place of the base register.
- R9: Mode 7: the address is `ext_word0` sign-extended, so it lies either in 000000–007FFF or in FF8000–FFFFFF.
- R10: Mode 8: the address is the low 24 bits of {`ext_word0`, `ext_word1`}, with `ext_word0` as the upper half.
- R11: `wb_en` is 1 only for a result from mode 1 or mode 2.
- R12: `out_align_err` is 1 exactly when the result's size code is not 0 and bit 0 of the address is 1. A byte access never flags.
- R13: All sums are computed modulo 2^32, and only bits 23:0 appear on `out_addr`. For example, FFFFFFFF plus 1 gives address 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing mode code 0..8 |
| req_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| base_reg | input | 32 | Selected address register value |
| index_reg | input | 32 | Selected index register value |
| ext_pc | input | 32 | Program counter at the extension word |
| ext_word0 | input | 16 | First extension word |
| ext_word1 | input | 16 | Second extension word (absolute long low half) |
| out_valid | output | 1 | Result valid |
| out_addr | output | 24 | External operand address |
| out_align_err | output | 1 | Word/long access at an odd address |
| wb_en | output | 1 | Write updated base register |
| wb_value | output | 32 | Updated base register value |

## Verification
A wrong operand-select or step entry shows up on `out_addr` or `wb_value` on the edge right after the request, because there is only one register stage. The scoreboard therefore compares every field on every result. The PC-relative and index cases are given distinct base, PC and index values, so swapping one operand for another changes the sum. Negative displacements and an all-ones base check sign extension and wraparound. Back-to-back requests with different modes expose any state left over from the previous cycle.

// File: rtl/ea_gen_pkg.sv
// Package: shared mode and size encodings for the effective address generator.
// Assumes mode codes 9..15 are unused and rejected by the top.
package ea_gen_pkg;
    typedef enum logic [3:0] {
        EA_IND     = 4'd0,
        EA_POSTINC = 4'd1,
        EA_PREDEC  = 4'd2,
        EA_DISP16  = 4'd3,
        EA_IDX8    = 4'd4,
        EA_PC16    = 4'd5,
        EA_PCIDX8  = 4'd6,
        EA_ABS16   = 4'd7,
        EA_ABS32   = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG2 = 2'd3
    } ea_size_e;

    localparam int unsigned MODE_COUNT = 9;
endpackage

// File: rtl/ea_step.sv
// Module: ea_step
// Converts the operand size code into the auto-modify step (1, 2 or 4).
// Assumes size codes 2 and 3 both mean a long operand.
module ea_step #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] step_o
);
    import ea_gen_pkg::*;

    ea_size_e sz;
    assign sz = ea_size_e'(size_i);

    // Purpose: select step by operand size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: step_o = DATA_W'(1);
            SZ_WORD: step_o = DATA_W'(2);
            default: step_o = DATA_W'(4);
        endcase
    end
endmodule

// File: rtl/ea_operand_sel.sv
// Module: ea_operand_sel
// Picks the three addends of the address sum for the given mode and
// sign-extends the displacement fields. Also flags the auto-modify modes.
// Assumes the extension words are already fetched and stable.
module ea_operand_sel #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EXT_W   = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [3:0]        mode_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] step_i,
    input  logic [EXT_W-1:0]  ext0_i,
    input  logic [EXT_W-1:0]  ext1_i,
    output logic [DATA_W-1:0] add_a_o,
    output logic [DATA_W-1:0] add_b_o,
    output logic [DATA_W-1:0] add_c_o,
    output logic              mode_ok_o,
    output logic              post_o,
    output logic              pre_o
);
    import ea_gen_pkg::*;

    localparam int unsigned LONG_W = 2 * EXT_W;

    ea_mode_e          md;
    logic [DATA_W-1:0] disp_long;
    logic [DATA_W-1:0] disp_short;
    logic [DATA_W-1:0] abs_long;

    assign md = ea_mode_e'(mode_i);

    // Purpose: sign-extend the 16-bit and 8-bit displacement fields.
    assign disp_long  = {{(DATA_W-EXT_W){ext0_i[EXT_W-1]}}, ext0_i};
    assign disp_short = {{(DATA_W-SHORT_W){ext0_i[SHORT_W-1]}}, ext0_i[SHORT_W-1:0]};

    // Purpose: assemble the absolute long value, upper word first.
    generate
        if (LONG_W >= DATA_W) begin : g_abs_trim
            logic [LONG_W-1:0] abs_cat;
            assign abs_cat  = {ext0_i, ext1_i};
            assign abs_long = abs_cat[DATA_W-1:0];
        end else begin : g_abs_pad
            assign abs_long = {{(DATA_W-LONG_W){1'b0}}, ext0_i, ext1_i};
        end
    endgenerate

    // Purpose: route the addends per addressing mode.
    always_comb begin
        add_a_o   = '0;
        add_b_o   = '0;
        add_c_o   = '0;
        mode_ok_o = 1'b1;
        post_o    = 1'b0;
        pre_o     = 1'b0;
        case (md)
            EA_IND:     add_a_o = base_i;
            EA_POSTINC: begin
                add_a_o = base_i;
                post_o  = 1'b1;
            end
            EA_PREDEC: begin
                add_a_o = base_i;
                add_b_o = ~step_i + DATA_W'(1);
                pre_o   = 1'b1;
            end
            EA_DISP16: begin
                add_a_o = base_i;
                add_b_o = disp_long;
            end
            EA_IDX8: begin
                add_a_o = base_i;
                add_b_o = index_i;
                add_c_o = disp_short;
            end
            EA_PC16: begin
                add_a_o = pc_i;
                add_b_o = disp_long;
            end
            EA_PCIDX8: begin
                add_a_o = pc_i;
                add_b_o = index_i;
                add_c_o = disp_short;
            end
            EA_ABS16:  add_a_o = disp_long;
            EA_ABS32:  add_a_o = abs_long;
            default:   mode_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ea_adder3.sv
// Module: ea_adder3
// Three-input modulo-2^DATA_W adder for the address sum.
// Assumes no carry-out is needed; overflow wraps.
module ea_adder3 #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] c_i,
    output logic [DATA_W-1:0] sum_o
);
    // Purpose: wrapping sum of the three addends.
    assign sum_o = a_i + b_i + c_i;
endmodule

// File: rtl/ea_gen.sv
// Module: ea_gen (top)
// Computes one operand address per request and registers the address,
// the alignment flag and the base-register write-back. One cycle latency.
// Assumes the upstream stage supplies register values and extension words.
module ea_gen #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned EXT_W   = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_mode,
    input  logic [1:0]        req_size,
    input  logic [31:0]       base_reg,
    input  logic [31:0]       index_reg,
    input  logic [31:0]       ext_pc,
    input  logic [15:0]       ext_word0,
    input  logic [15:0]       ext_word1,
    output logic              out_valid,
    output logic [23:0]       out_addr,
    output logic              out_align_err,
    output logic              wb_en,
    output logic [31:0]       wb_value
);
    import ea_gen_pkg::*;

    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] add_a, add_b, add_c;
    logic [DATA_W-1:0] ea_sum;
    logic [DATA_W-1:0] post_val;
    logic              mode_ok, is_post, is_pre, take;

    ea_step #(.DATA_W(DATA_W)) u_step (
        .size_i (req_size),
        .step_o (step)
    );

    ea_operand_sel #(
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W),
        .SHORT_W(SHORT_W)
    ) u_sel (
        .mode_i   (req_mode),
        .base_i   (base_reg),
        .index_i  (index_reg),
        .pc_i     (ext_pc),
        .step_i   (step),
        .ext0_i   (ext_word0),
        .ext1_i   (ext_word1),
        .add_a_o  (add_a),
        .add_b_o  (add_b),
        .add_c_o  (add_c),
        .mode_ok_o(mode_ok),
        .post_o   (is_post),
        .pre_o    (is_pre)
    );

    ea_adder3 #(.DATA_W(DATA_W)) u_sum (
        .a_i  (add_a),
        .b_i  (add_b),
        .c_i  (add_c),
        .sum_o(ea_sum)
    );

    // Purpose: incremented base for post-increment write-back.
    assign post_val = base_reg + step;
    assign take     = req_valid && mode_ok;

    // Purpose: register the result, clearing strobes when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_addr      <= '0;
            out_align_err <= 1'b0;
            wb_en         <= 1'b0;
            wb_value      <= '0;
        end else begin
            out_valid     <= take;
            out_align_err <= take && (req_size != SZ_BYTE) && ea_sum[0];
            wb_en         <= take && (is_post || is_pre);
            if (take) begin
                out_addr <= ea_sum[ADDR_W-1:0];
                wb_value <= is_post ? post_val : (is_pre ? ea_sum : '0);
            end
        end
    end
endmodule

// File: rtl/ea_gen_checker.sv
// Module: ea_gen_checker
// Temporal checks on the ports of ea_gen, attached with bind.
module ea_gen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_mode,
    input logic [1:0]  req_size,
    input logic [31:0] base_reg,
    input logic        out_valid,
    input logic [23:0] out_addr,
    input logic        out_align_err,
    input logic        wb_en,
    input logic [31:0] wb_value
);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode < 4'd9) |=> out_valid);

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode >= 4'd9) |=> !out_valid);

    assert_wb_modes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (out_valid && ($past(req_mode) == 4'd1 || $past(req_mode) == 4'd2)));

    assert_ind_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_mode) == 4'd0) |-> (out_addr == $past(base_reg[23:0]) && !wb_en));

    assert_post_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_mode) == 4'd1) |-> out_addr == $past(base_reg[23:0]));

    assert_pre_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_mode) == 4'd2) |-> (wb_en && out_addr == wb_value[23:0]));

    assert_abs16_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_mode) == 4'd7) |-> (&out_addr[23:15] || ~|out_addr[23:15]));

    assert_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_align_err |-> (out_valid && out_addr[0] && $past(req_size) != 2'd0));
endmodule

bind ea_gen ea_gen_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_size     (req_size),
    .base_reg     (base_reg),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_align_err(out_align_err),
    .wb_en        (wb_en),
    .wb_value     (wb_value)
);

// File: tb/tb_ea_gen.sv
// Bench: scoreboard. Driver pushes the expected result of each request;
// monitor pops one item per clock after the edge and compares.
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] base_reg = '0, index_reg = '0, ext_pc = '0;
    logic [15:0] ext_word0 = '0, ext_word1 = '0;
    logic        out_valid, out_align_err, wb_en;
    logic [23:0] out_addr;
    logic [31:0] wb_value;

    typedef struct packed {
        logic        vld;
        logic [23:0] addr;
        logic        err;
        logic        wb;
        logic [31:0] wbv;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_total = 0, n_fail = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .base_reg(base_reg), .index_reg(index_reg),
        .ext_pc(ext_pc), .ext_word0(ext_word0), .ext_word1(ext_word1),
        .out_valid(out_valid), .out_addr(out_addr), .out_align_err(out_align_err),
        .wb_en(wb_en), .wb_value(wb_value)
    );

    function automatic exp_t model(input logic [3:0] m, input logic [1:0] s,
                                   input logic [31:0] b, input logic [31:0] x,
                                   input logic [31:0] p, input logic [15:0] e0,
                                   input logic [15:0] e1);
        exp_t r;
        logic [31:0] st, a, s16, s8, wv;
        st  = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
        s16 = {{16{e0[15]}}, e0};
        s8  = {{24{e0[7]}}, e0[7:0]};
        a = 32'd0; wv = 32'd0; r.wb = 1'b0; r.vld = 1'b1;
        case (m)
            4'd0: a = b;
            4'd1: begin a = b; wv = b + st; r.wb = 1'b1; end
            4'd2: begin a = b - st; wv = a; r.wb = 1'b1; end
            4'd3: a = b + s16;
            4'd4: a = b + x + s8;
            4'd5: a = p + s16;
            4'd6: a = p + x + s8;
            4'd7: a = s16;
            4'd8: a = {e0, e1};
            default: r.vld = 1'b0;
        endcase
        r.addr = a[23:0];
        r.err  = r.vld && (s != 2'd0) && a[0];
        r.wbv  = wv;
        if (!r.vld) begin r.wb = 1'b0; r.err = 1'b0; end
        return r;
    endfunction

    task automatic drive(input string tag, input logic [3:0] m, input logic [1:0] s,
                         input logic [31:0] b, input logic [31:0] x,
                         input logic [31:0] p, input logic [15:0] e0,
                         input logic [15:0] e1);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_size = s; base_reg = b;
        index_reg = x; ext_pc = p; ext_word0 = e0; ext_word1 = e1;
        q_exp.push_back(model(m, s, b, x, p, e0, e1));
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare the registered outputs one step after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_total++;
            if (out_valid !== e.vld ||
                (e.vld && (out_addr !== e.addr || out_align_err !== e.err ||
                           wb_en !== e.wb || (e.wb && wb_value !== e.wbv)))) begin
                n_fail++;
                $display("FAIL %s: got v=%0b a=%06h e=%0b wb=%0b wv=%08h exp v=%0b a=%06h e=%0b wb=%0b wv=%08h",
                         t, out_valid, out_addr, out_align_err, wb_en, wb_value,
                         e.vld, e.addr, e.err, e.wb, e.wbv);
            end
        end else if (rst_n && out_valid === 1'b1) begin
            n_total++;
            n_fail++;
            $display("FAIL R2: unexpected out_valid=1 expected 0");
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_total++;                                                  // R1
        if (out_valid !== 1'b0 || wb_en !== 1'b0 || out_align_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: v=%0b wb=%0b err=%0b expected 0 0 0", out_valid, wb_en, out_align_err);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        n_total++;                                                  // R1 first edge
        if (out_valid !== 1'b0 || wb_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after release v=%0b wb=%0b expected 0 0", out_valid, wb_en);
        end
        drive("R3",  4'd0, 2'd1, 32'h1234_5678, 0, 0, 16'h0, 16'h0);
        drive("R4",  4'd1, 2'd0, 32'h0000_1000, 0, 0, 16'h0, 16'h0);
        drive("R4",  4'd1, 2'd1, 32'h0000_2000, 0, 0, 16'h0, 16'h0);
        drive("R4",  4'd1, 2'd2, 32'h0000_3000, 0, 0, 16'h0, 16'h0);
        drive("R4",  4'd1, 2'd3, 32'h0000_3100, 0, 0, 16'h0, 16'h0);
        drive("R5",  4'd2, 2'd0, 32'h0000_1000, 0, 0, 16'h0, 16'h0);
        drive("R5",  4'd2, 2'd1, 32'h0000_2000, 0, 0, 16'h0, 16'h0);
        drive("R5",  4'd2, 2'd2, 32'h0000_3000, 0, 0, 16'h0, 16'h0);
        drive("R6",  4'd3, 2'd1, 32'h0000_5000, 32'h77, 32'h900, 16'hFFF0, 16'h0);
        drive("R6",  4'd3, 2'd1, 32'h0000_5000, 32'h77, 32'h900, 16'h0100, 16'h0);
        drive("R7",  4'd4, 2'd1, 32'h0000_5000, 32'h6, 32'h900, 16'h0080, 16'h0);
        drive("R7",  4'd4, 2'd0, 32'h0000_5000, 32'hFFFF_FFFE, 32'h900, 16'h7F10, 16'h0);
        drive("R8",  4'd5, 2'd1, 32'h0000_5000, 32'h6, 32'h1002, 16'h0064, 16'h0);
        drive("R8",  4'd6, 2'd1, 32'h0000_5000, 32'h6, 32'h1002, 16'h0064, 16'h0);
        drive("R9",  4'd7, 2'd1, 32'h0000_5000, 0, 0, 16'h8000, 16'h0);
        drive("R9",  4'd7, 2'd1, 32'h0000_5000, 0, 0, 16'h7FFE, 16'h0);
        drive("R10", 4'd8, 2'd0, 32'h0000_5000, 0, 0, 16'h12AB, 16'hCDEF);
        drive("R12", 4'd0, 2'd1, 32'h0000_1001, 0, 0, 16'h0, 16'h0);
        drive("R12", 4'd0, 2'd0, 32'h0000_1001, 0, 0, 16'h0, 16'h0);
        drive("R12", 4'd1, 2'd2, 32'h0000_2001, 0, 0, 16'h0, 16'h0);
        drive("R13", 4'd3, 2'd0, 32'hFFFF_FFFF, 0, 0, 16'h0001, 16'h0);
        drive("R2",  4'd9, 2'd1, 32'h0000_4000, 0, 0, 16'h0, 16'h0);
        drive("R11", 4'd5, 2'd0, 32'h0000_4000, 0, 32'h2000, 16'h0003, 16'h0);
        drive("R2",  4'd15, 2'd1, 32'h0000_4000, 0, 0, 16'h0, 16'h0);
        idle(4);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule